// File: doc/BRIEF.md
# Privileged Address Segment Decoder

This block takes a 32-bit virtual address and sorts it into a segment. The choice depends on the top address bits, the current privilege level and an error-level status bit. The result is one of three things:

- a request for a TLB lookup,
- a direct physical address for an unmapped window,
- an address error for a reference the current privilege may not make.

The block is purely combinational. It sits in front of the translation buffer, which is used only when the block raises its lookup flag.

A second strap input, `fixedMap`, selects a simpler mapping scheme for systems without a TLB. In that scheme the mapped segments are translated by fixed rules, so the lookup flag never rises. The privilege checks still apply in both schemes.

Top module: `seg_decoder`

## Requirements
- R1: Privilege encoding on `privMode`: 2'b10 is user and 2'b01 is supervisor. Both 2'b00 and 2'b11 are kernel, because kernel means neither user nor supervisor.
- R2: When `errLevel`=0 and `fixedMap`=0, an address with bit 31 clear raises `needTlb` in every privilege level.
- R3: When `errLevel`=1, an address with bit 31 clear gives `physAddr` equal to `vAddr`, with `needTlb`=0 and `badAddr`=0. This holds in both mapping schemes.
- R4: In kernel level, addresses 0x80000000..0x9FFFFFFF give `physAddr` equal to `vAddr` minus 0x80000000, and addresses 0xA0000000..0xBFFFFFFF give `vAddr` minus 0xA0000000. No lookup is raised for either range.
- R5: Addresses 0x80000000..0xBFFFFFFF raise `badAddr` in user or supervisor level.
- R6: Addresses 0xC0000000..0xDFFFFFFF raise `badAddr` in user level and are mapped in supervisor or kernel level.
- R7: Addresses 0xE0000000..0xFFFFFFFF are mapped in kernel level only. User and supervisor levels raise `badAddr` for them.
- R8: When `fixedMap`=1 and `errLevel`=0, an address with bit 31 clear gives `physAddr` equal to `vAddr` plus 0x40000000, with no lookup.
- R9: When `fixedMap`=1, a permitted address in 0xC0000000..0xFFFFFFFF gives `physAddr` equal to `vAddr` and raises no lookup.
- R10: `errLevel` has no effect on any output for addresses with bit 31 set.
- R11: `needTlb` and `badAddr` are never high together. Whenever either one is high, `physAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vAddr | input | 32 | Virtual address to decode |
| privMode | input | 2 | Privilege level (see R1) |
| errLevel | input | 1 | Error-level status bit |
| fixedMap | input | 1 | Selects the fixed-mapping scheme |
| needTlb | output | 1 | Address must be translated by the TLB |
| badAddr | output | 1 | Reference not permitted at this privilege |
| physAddr | output | 32 | Direct physical address, zero when not direct |

## Verification
Two rules both claim a low-segment address when `errLevel` and `fixedMap` are set together: the identity bypass and the fixed +0x40000000 offset. The bench drives that combination in directed cases and again many times in random draws. Each result is judged against a reference function in which the error-level bypass wins. The random stream also mixes `errLevel` into high-segment addresses, so the bench can confirm the bit is ignored there.

// File: rtl/seg_decoder_pkg.sv
package seg_decoder_pkg;

  typedef enum logic [1:0] {
    MODE_KERNEL  = 2'b00,
    MODE_SUPER   = 2'b01,
    MODE_USER    = 2'b10,
    MODE_KERNEL2 = 2'b11
  } privMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic selIdent;   // pass address through
    logic selOffset;  // add fixed offset
    logic selLow;     // keep low window bits
    logic needTlb;
    logic badAddr;
  } segStrobes_t;

endpackage

// File: rtl/seg_decoder_ctrl.sv
module seg_decoder_ctrl
  import seg_decoder_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vAddr,
  input  privMode_t         mode,
  input  logic              errLevel,
  input  logic              fixedMap,
  output segStrobes_t       strobes
);

  localparam int TOP = ADDR_W - 1;

  logic [2:0] segBits;
  logic       isUser;
  logic       isSuper;
  logic       isKernel;

  assign segBits  = vAddr[TOP -: 3];
  assign isUser   = (mode == MODE_USER);
  assign isSuper  = (mode == MODE_SUPER);
  assign isKernel = !isUser && !isSuper;

  always_comb begin
    strobes = '0;
    if (!segBits[2]) begin
      // low segment, open to every level
      if (errLevel)      strobes.selIdent  = 1'b1;
      else if (fixedMap) strobes.selOffset = 1'b1;
      else               strobes.needTlb   = 1'b1;
    end else if (!segBits[1]) begin
      // two unmapped kernel windows
      if (isKernel) strobes.selLow  = 1'b1;
      else          strobes.badAddr = 1'b1;
    end else if (!segBits[0]) begin
      if (isUser)        strobes.badAddr  = 1'b1;
      else if (fixedMap) strobes.selIdent = 1'b1;
      else               strobes.needTlb  = 1'b1;
    end else begin
      if (!isKernel)     strobes.badAddr  = 1'b1;
      else if (fixedMap) strobes.selIdent = 1'b1;
      else               strobes.needTlb  = 1'b1;
    end
  end

endmodule

// File: rtl/seg_decoder_dp.sv
module seg_decoder_dp
  import seg_decoder_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] FIXED_OFFS = 32'h4000_0000
) (
  input  logic [ADDR_W-1:0] vAddr,
  input  segStrobes_t       strobes,
  output logic [ADDR_W-1:0] physAddr
);

  localparam int LOW_W = ADDR_W - 3;

  logic [ADDR_W-1:0] lowWin;
  assign lowWin = {3'b000, vAddr[LOW_W-1:0]};

  always_comb begin
    if (strobes.selIdent)       physAddr = vAddr;
    else if (strobes.selOffset) physAddr = vAddr + FIXED_OFFS;
    else if (strobes.selLow)    physAddr = lowWin;
    else                        physAddr = '0;
  end

endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_decoder_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] FIXED_OFFS = 32'h4000_0000
) (
  input  logic [ADDR_W-1:0] vAddr,
  input  logic [1:0]        privMode,
  input  logic              errLevel,
  input  logic              fixedMap,
  output logic              needTlb,
  output logic              badAddr,
  output logic [ADDR_W-1:0] physAddr
);

  segStrobes_t strobes;
  privMode_t   modeTyped;

  assign modeTyped = privMode_t'(privMode);

  seg_decoder_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .vAddr    (vAddr),
    .mode     (modeTyped),
    .errLevel (errLevel),
    .fixedMap (fixedMap),
    .strobes  (strobes)
  );

  seg_decoder_dp #(.ADDR_W(ADDR_W), .FIXED_OFFS(FIXED_OFFS)) uDp (
    .vAddr    (vAddr),
    .strobes  (strobes),
    .physAddr (physAddr)
  );

  assign needTlb = strobes.needTlb;
  assign badAddr = strobes.badAddr;

endmodule

// File: rtl/seg_decoder_chk.sv
module seg_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic [ADDR_W-1:0] vAddr,
  input logic [1:0]        privMode,
  input logic              errLevel,
  input logic              fixedMap,
  input logic              needTlb,
  input logic              badAddr,
  input logic [ADDR_W-1:0] physAddr
);

  logic known;
  assign known = !$isunknown({vAddr, privMode, errLevel, fixedMap});

  always_comb begin
    if (known) begin
      // R11
      excl_chk: assert (!(needTlb && badAddr));
      // R11
      zero_phys_chk: assert (!(needTlb || badAddr) || physAddr == '0);
      // R2
      low_never_bad_chk: assert (vAddr[ADDR_W-1] || !badAddr);
      // R3
      erl_ident_chk: assert (vAddr[ADDR_W-1] || !errLevel || (physAddr == vAddr && !needTlb));
      // R7
      kernel_never_bad_chk: assert (privMode == 2'b01 || privMode == 2'b10 || !badAddr);
      // R9
      fixed_no_tlb_chk: assert (!fixedMap || !needTlb);
    end
  end

endmodule

bind seg_decoder seg_decoder_chk #(.ADDR_W(ADDR_W)) uChk (
  .vAddr    (vAddr),
  .privMode (privMode),
  .errLevel (errLevel),
  .fixedMap (fixedMap),
  .needTlb  (needTlb),
  .badAddr  (badAddr),
  .physAddr (physAddr)
);

// File: tb/seg_decoder_test.sv
`timescale 1ns/1ps
module seg_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] vAddr = '0;
  logic [1:0]  privMode = '0;
  logic        errLevel = 1'b0;
  logic        fixedMap = 1'b0;
  logic        needTlb, badAddr;
  logic [31:0] physAddr;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  seg_decoder uut (
    .vAddr(vAddr), .privMode(privMode), .errLevel(errLevel), .fixedMap(fixedMap),
    .needTlb(needTlb), .badAddr(badAddr), .physAddr(physAddr)
  );

  // reference model built from the requirements
  function automatic logic [33:0] refModel(logic [31:0] va, logic [1:0] md, logic erl, logic fm);
    logic usr, sup, krn, tlb, bad;
    logic [31:0] pa;
    usr = (md == 2'b10); sup = (md == 2'b01); krn = !usr && !sup;
    tlb = 0; bad = 0; pa = 0;
    if (va < 32'h8000_0000) begin
      if (erl) pa = va;
      else if (fm) pa = va + 32'h4000_0000;
      else tlb = 1;
    end else if (va < 32'hA000_0000) begin
      if (krn) pa = va - 32'h8000_0000; else bad = 1;
    end else if (va < 32'hC000_0000) begin
      if (krn) pa = va - 32'hA000_0000; else bad = 1;
    end else if (va < 32'hE000_0000) begin
      if (usr) bad = 1; else if (fm) pa = va; else tlb = 1;
    end else begin
      if (!krn) bad = 1; else if (fm) pa = va; else tlb = 1;
    end
    return {tlb, bad, pa};
  endfunction

  function automatic string reqTag(logic [31:0] va, logic [1:0] md, logic erl, logic fm);
    if (va < 32'h8000_0000) return erl ? "R3" : (fm ? "R8" : "R2");
    if (va < 32'hC000_0000) return (md == 2'b01 || md == 2'b10) ? "R5" : "R4";
    if (fm) return "R9";
    if (va < 32'hE000_0000) return "R6";
    return "R7";
  endfunction

  task automatic apply(logic [31:0] va, logic [1:0] md, logic erl, logic fm, string tag);
    logic [33:0] exp;
    vAddr = va; privMode = md; errLevel = erl; fixedMap = fm;
    @(negedge clk);
    exp = refModel(va, md, erl, fm);
    checks++;
    if ({needTlb, badAddr, physAddr} !== exp) begin
      errors++;
      $display("FAIL %s va=%h mode=%0d erl=%0b fm=%0b got tlb=%0b bad=%0b pa=%h exp tlb=%0b bad=%0b pa=%h",
               tag, va, md, erl, fm, needTlb, badAddr, physAddr, exp[33], exp[32], exp[31:0]);
    end
    // R11 exclusivity and zero physical address on lookup or error
    checks++;
    if ((needTlb && badAddr) || ((needTlb || badAddr) && physAddr != 0)) begin
      errors++;
      $display("FAIL R11 tlb=%0b bad=%0b pa=%h exp exclusive flags and zero pa", needTlb, badAddr, physAddr);
    end
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state: zero inputs, low segment in kernel -> lookup (R2)
    apply(32'h0, 2'b00, 0, 0, "R2");
    // R1: every privilege code on segment edges
    for (int m = 0; m < 4; m++) begin
      apply(32'h7FFF_FFFF, 2'(m), 0, 0, "R1");
      apply(32'h8000_0000, 2'(m), 0, 0, "R1");
      apply(32'h9FFF_FFFF, 2'(m), 0, 0, "R4");
      apply(32'hA000_0000, 2'(m), 0, 0, "R4");
      apply(32'hBFFF_FFFF, 2'(m), 1, 0, "R10");
      apply(32'hC000_0000, 2'(m), 0, 0, "R6");
      apply(32'hDFFF_FFFF, 2'(m), 1, 0, "R6");
      apply(32'hE000_0000, 2'(m), 0, 0, "R7");
      apply(32'hFFFF_FFFF, 2'(m), 1, 1, "R9");
      apply(32'hC123_4560, 2'(m), 0, 1, "R9");
    end
    // R3 vs R8: error level and fixed map together
    apply(32'h7FFF_FFFF, 2'b10, 1, 1, "R3");
    apply(32'h1234_5678, 2'b01, 1, 1, "R3");
    apply(32'h7FFF_FFFF, 2'b10, 0, 1, "R8");
    apply(32'h0000_0000, 2'b00, 0, 1, "R8");
    // R10: error level toggled on high segments
    apply(32'h8765_4321, 2'b00, 1, 0, "R10");
    apply(32'hE000_1000, 2'b00, 1, 0, "R10");
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] va;
      logic [1:0]  md;
      logic        erl, fm;
      va  = $urandom;
      md  = 2'($urandom);
      erl = 1'($urandom);
      fm  = 1'($urandom);
      apply(va, md, erl, fm, reqTag(va, md, erl, fm));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired checks=%0d expected completion", checks);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule